// File: doc/BRIEF.md
# Coordinate Step Calculator with Antimeridian Wrap

This block takes successive position fixes, each a signed latitude word and a signed longitude word in fixed-point degrees (one LSB is one millionth of a degree), and reports how far the position moved between the latest fix and the one before it. A pulse on the sample strobe presents a new fix. One cycle later the block returns the latitude step and the longitude step as wider signed words, together with a one-cycle valid pulse. A downstream stage that computes heading and ground speed consumes these outputs.

A longitude difference taken naively across the ±180 degree line would be close to ±360 degrees, even though the craft moved only a short distance. The block detects this case. Both fixes must lie beyond a configurable longitude magnitude and must lie on opposite sides of zero. When that holds, the block adds one full turn to whichever fix is negative, so the step it reports stays small and keeps the correct sign. Latitude never wraps and is always a plain difference.

Control and datapath are separate modules. The control tracks whether a previous fix is held and issues strobes to the datapath. The datapath holds the previous fix, applies the wrap correction and forms both differences.

Top module: `coord_delta_wrap`

## Requirements
- R1: While reset is held and directly after it, `stepValid` is 0 and `latStep` and `lonStep` are 0.
- R2: The first strobe after reset only stores the fix. `stepValid` stays 0 in the following cycle and the step outputs do not change.
- R3: For every later strobe, in the cycle after the strobe `stepValid` is 1 for exactly one cycle and `latStep` equals the new latitude minus the previous latitude, as a 33-bit signed value.
- R4: When both longitudes share a sign (zero counts as non-negative), `lonStep` equals the new longitude minus the previous longitude.
- R5: When the signs differ but either longitude has a magnitude at or below `WRAP_DEG` degrees (default 170, that is 170,000,000 LSB), `lonStep` is the plain difference.
- R6: When the signs differ and both magnitudes exceed the threshold, 360,000,000 LSB is added to the negative longitude before subtracting. A move from +179.999999 to -179.999999 gives +2 LSB, and the reverse move gives -2 LSB.
- R7: Without a strobe, `latStep` and `lonStep` hold their values and `stepValid` is 0.
- R8: Strobes on back-to-back cycles each produce a step against the fix of the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fixStb | input | 1 | A new fix is present on the coordinate inputs |
| latIn | input | 32 | Latitude, signed, 1e-6 degree per LSB |
| lonIn | input | 32 | Longitude, signed, 1e-6 degree per LSB |
| latStep | output | 33 | Latitude step, signed |
| lonStep | output | 33 | Longitude step, signed, wrap-corrected |
| stepValid | output | 1 | One-cycle pulse when new steps are presented |

## Verification
On a single clock edge the block both forms a difference against the stored fix and overwrites that fix with the incoming one. The step must therefore use the old stored value and not the one being written. The bench provokes this overlap by holding the strobe high for two consecutive cycles, once with an antimeridian crossing in the pair. It then checks that each of the two steps equals the difference against the immediately preceding fix, computed independently in the bench.

// File: rtl/coord_delta_pkg.sv
package coord_delta_pkg;
  typedef struct packed {
    logic loadFix;
    logic emitStep;
  } stepCtl_t;

  typedef enum logic {
    HIST_EMPTY  = 1'b0,
    HIST_PRIMED = 1'b1
  } histState_t;
endpackage

// File: rtl/coord_delta_ctrl.sv
module coord_delta_ctrl
  import coord_delta_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     fixStb,
  output stepCtl_t ctl,
  output logic     stepValid
);
  histState_t histState;

  always_comb begin
    ctl.loadFix  = fixStb;
    ctl.emitStep = fixStb && (histState == HIST_PRIMED);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histState <= HIST_EMPTY;
      stepValid <= 1'b0;
    end else begin
      stepValid <= ctl.emitStep;
      if (fixStb) histState <= HIST_PRIMED;
    end
  end
endmodule

// File: rtl/coord_wrap_fix.sv
module coord_wrap_fix #(
  parameter int COORD_W   = 32,
  parameter int DEG_SCALE = 1000000,
  parameter int WRAP_DEG  = 170
) (
  input  logic signed [COORD_W-1:0] oldLon,
  input  logic signed [COORD_W-1:0] newLon,
  output logic signed [COORD_W:0]   oldAdj,
  output logic signed [COORD_W:0]   newAdj
);
  localparam int OUT_W = COORD_W + 1;
  localparam logic signed [OUT_W-1:0] FULL_TURN  = OUT_W'(360 * DEG_SCALE);
  localparam logic signed [OUT_W-1:0] NEAR_LIMIT = OUT_W'(WRAP_DEG * DEG_SCALE);

  logic signed [OUT_W-1:0] ext [2];
  logic signed [OUT_W-1:0] mag [2];
  logic                    neg [2];
  logic                    nearBorder;

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : gOperand
      always_comb begin
        if (gi == 0) ext[gi] = {oldLon[COORD_W-1], oldLon};
        else         ext[gi] = {newLon[COORD_W-1], newLon};
        neg[gi] = ext[gi][OUT_W-1];
        mag[gi] = neg[gi] ? -ext[gi] : ext[gi];
      end
    end
  endgenerate

  always_comb begin
    nearBorder = (mag[0] > NEAR_LIMIT) && (mag[1] > NEAR_LIMIT) && (neg[0] != neg[1]);
    oldAdj = (nearBorder && neg[0]) ? ext[0] + FULL_TURN : ext[0];
    newAdj = (nearBorder && neg[1]) ? ext[1] + FULL_TURN : ext[1];
  end
endmodule

// File: rtl/coord_delta_path.sv
module coord_delta_path
  import coord_delta_pkg::*;
#(
  parameter int COORD_W   = 32,
  parameter int DEG_SCALE = 1000000,
  parameter int WRAP_DEG  = 170
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  stepCtl_t                  ctl,
  input  logic signed [COORD_W-1:0] latIn,
  input  logic signed [COORD_W-1:0] lonIn,
  output logic signed [COORD_W:0]   latStep,
  output logic signed [COORD_W:0]   lonStep
);
  localparam int OUT_W = COORD_W + 1;

  logic signed [COORD_W-1:0] prevLat, prevLon;
  logic signed [OUT_W-1:0]   oldLonAdj, newLonAdj;
  logic signed [OUT_W-1:0]   latDiff, lonDiff;

  coord_wrap_fix #(
    .COORD_W(COORD_W), .DEG_SCALE(DEG_SCALE), .WRAP_DEG(WRAP_DEG)
  ) wrapFix (
    .oldLon(prevLon), .newLon(lonIn), .oldAdj(oldLonAdj), .newAdj(newLonAdj)
  );

  always_comb begin
    latDiff = {latIn[COORD_W-1], latIn} - {prevLat[COORD_W-1], prevLat};
    lonDiff = newLonAdj - oldLonAdj;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLat <= '0;
      prevLon <= '0;
      latStep <= '0;
      lonStep <= '0;
    end else begin
      if (ctl.loadFix) begin
        prevLat <= latIn;
        prevLon <= lonIn;
      end
      if (ctl.emitStep) begin
        latStep <= latDiff;
        lonStep <= lonDiff;
      end
    end
  end
endmodule

// File: rtl/coord_delta_wrap.sv
module coord_delta_wrap
  import coord_delta_pkg::*;
#(
  parameter int COORD_W   = 32,
  parameter int DEG_SCALE = 1000000,
  parameter int WRAP_DEG  = 170
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      fixStb,
  input  logic signed [COORD_W-1:0] latIn,
  input  logic signed [COORD_W-1:0] lonIn,
  output logic signed [COORD_W:0]   latStep,
  output logic signed [COORD_W:0]   lonStep,
  output logic                      stepValid
);
  stepCtl_t ctl;

  coord_delta_ctrl ctrlUnit (
    .clk(clk), .rstN(rstN), .fixStb(fixStb), .ctl(ctl), .stepValid(stepValid)
  );

  coord_delta_path #(
    .COORD_W(COORD_W), .DEG_SCALE(DEG_SCALE), .WRAP_DEG(WRAP_DEG)
  ) pathUnit (
    .clk(clk), .rstN(rstN), .ctl(ctl), .latIn(latIn), .lonIn(lonIn),
    .latStep(latStep), .lonStep(lonStep)
  );
endmodule

// File: rtl/coord_delta_wrap_chk.sv
module coord_delta_wrap_chk #(
  parameter int COORD_W   = 32,
  parameter int DEG_SCALE = 1000000,
  parameter int WRAP_DEG  = 170
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      fixStb,
  input logic signed [COORD_W-1:0] latIn,
  input logic signed [COORD_W-1:0] lonIn,
  input logic signed [COORD_W:0]   latStep,
  input logic signed [COORD_W:0]   lonStep,
  input logic                      stepValid
);
  localparam int OUT_W = COORD_W + 1;
  localparam logic signed [OUT_W-1:0] LIMIT = OUT_W'(WRAP_DEG * DEG_SCALE);
  localparam logic signed [OUT_W-1:0] WIN   = OUT_W'(2 * (180 - WRAP_DEG) * DEG_SCALE);

  logic                      seen;
  logic signed [COORD_W-1:0] shLat, shLon;
  logic signed [OUT_W-1:0]   lonExt, shExt, lonMag, shMag;
  logic                      crossNow, sameSign;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen  <= 1'b0;
      shLat <= '0;
      shLon <= '0;
    end else if (fixStb) begin
      seen  <= 1'b1;
      shLat <= latIn;
      shLon <= lonIn;
    end
  end

  always_comb begin
    lonExt   = {lonIn[COORD_W-1], lonIn};
    shExt    = {shLon[COORD_W-1], shLon};
    lonMag   = lonExt[OUT_W-1] ? -lonExt : lonExt;
    shMag    = shExt[OUT_W-1] ? -shExt : shExt;
    sameSign = (lonIn[COORD_W-1] == shLon[COORD_W-1]);
    crossNow = !sameSign && (lonMag > LIMIT) && (shMag > LIMIT);
  end

  AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (fixStb && !seen) |=> !stepValid); // R2
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && !fixStb) |=> !stepValid); // R3
  AST_LAT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (fixStb && seen) |=> (stepValid && latStep == ($past({latIn[COORD_W-1], latIn}) - $past({shLat[COORD_W-1], shLat})))); // R3
  AST_SAME_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (fixStb && seen && sameSign) |=> (lonStep == ($past(lonExt) - $past(shExt)))); // R4
  AST_CROSS_SMALL: assert property (@(posedge clk) disable iff (!rstN)
    (fixStb && seen && crossNow) |=> (lonStep <= WIN && lonStep >= -WIN)); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !fixStb |=> ($stable(latStep) && $stable(lonStep) && !stepValid)); // R7
endmodule

bind coord_delta_wrap coord_delta_wrap_chk #(
  .COORD_W(COORD_W), .DEG_SCALE(DEG_SCALE), .WRAP_DEG(WRAP_DEG)
) chkInst (
  .clk(clk), .rstN(rstN), .fixStb(fixStb), .latIn(latIn), .lonIn(lonIn),
  .latStep(latStep), .lonStep(lonStep), .stepValid(stepValid)
);

// File: tb/coord_delta_wrap_test.sv
module coord_delta_wrap_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fixStb = 1'b0;
  logic signed [31:0] latIn = '0, lonIn = '0;
  logic signed [32:0] latStep, lonStep;
  logic stepValid;
  int checks = 0;
  int errors = 0;
  logic signed [31:0] refLat, refLon;

  always #10 clk = ~clk;

  coord_delta_wrap uut (
    .clk(clk), .rstN(rstN), .fixStb(fixStb), .latIn(latIn), .lonIn(lonIn),
    .latStep(latStep), .lonStep(lonStep), .stepValid(stepValid)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expLon(longint oldV, longint newV);
    longint o = oldV, n = newV;
    longint mo = (o < 0) ? -o : o;
    longint mn = (n < 0) ? -n : n;
    if (mo > 170000000 && mn > 170000000 && ((o < 0) != (n < 0))) begin
      if (o < 0) o += 360000000;
      if (n < 0) n += 360000000;
    end
    return n - o;
  endfunction

  // one strobe; outputs checked at the negedge following the capturing edge
  task automatic feed(string req, logic signed [31:0] la, logic signed [31:0] lo);
    @(negedge clk);
    fixStb = 1'b1; latIn = la; lonIn = lo;
    @(negedge clk);
    fixStb = 1'b0;
    check({req, " valid"}, stepValid, 1);
    check({req, " lat"}, latStep, longint'(la) - longint'(refLat));
    check({req, " lon"}, lonStep, expLon(refLon, lo));
    refLat = la; refLon = lo;
  endtask

  task automatic testReset();
    check("R1 valid", stepValid, 0);
    check("R1 lat", latStep, 0);
    check("R1 lon", lonStep, 0);
  endtask

  task automatic testFirst();
    @(negedge clk);
    fixStb = 1'b1; latIn = 32'sd45000000; lonIn = 32'sd10000000;
    @(negedge clk);
    fixStb = 1'b0;
    check("R2 valid", stepValid, 0);
    check("R2 lat", latStep, 0);
    check("R2 lon", lonStep, 0);
    refLat = 32'sd45000000; refLon = 32'sd10000000;
  endtask

  task automatic testSameSign();
    feed("R3 R4 pos", 32'sd45000030, 32'sd10000050);
    feed("R3 R4 neg", -32'sd30000000, -32'sd75000000);
    feed("R3 R4 negstep", -32'sd30000011, -32'sd75000020);
  endtask

  task automatic testMixedFar();
    feed("R5 zero cross", -32'sd30000000, 32'sd12);
    feed("R5 zero back", -32'sd30000000, -32'sd9);
    feed("R5 one near", 1000, 32'sd175000000);
    feed("R5 other far", 1000, -32'sd100000000);
  endtask

  task automatic testCross();
    feed("R6 setup", 0, 32'sd179999999);
    check("R6 east to west", lonStep, longint'(32'sd179999999) - longint'(-32'sd100000000));
    feed("R6 east to west", 0, -32'sd179999999);
    check("R6 plus two", lonStep, 2);
    feed("R6 west to east", 0, 32'sd179999999);
    check("R6 minus two", lonStep, -2);
  endtask

  task automatic testThreshold();
    feed("R5 at limit a", 0, 32'sd170000000);
    feed("R5 at limit b", 0, -32'sd170000000);
    check("R5 at limit plain", lonStep, -340000000);
    feed("R6 above limit a", 0, 32'sd171000000);
    feed("R6 above limit b", 0, -32'sd171000000);
    check("R6 above limit", lonStep, 18000000);
  endtask

  task automatic testHold();
    logic signed [32:0] la = latStep, lo = lonStep;
    @(negedge clk);
    latIn = 32'sd5; lonIn = -32'sd5;
    @(negedge clk);
    @(negedge clk);
    check("R7 valid", stepValid, 0);
    check("R7 lat", latStep, la);
    check("R7 lon", lonStep, lo);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    fixStb = 1'b1; latIn = 32'sd100; lonIn = 32'sd179999000;
    @(negedge clk);
    check("R8 first valid", stepValid, 1);
    check("R8 first lon", lonStep, expLon(refLon, 32'sd179999000));
    check("R8 first lat", latStep, 100 - longint'(refLat));
    latIn = 32'sd250; lonIn = -32'sd179999500;
    @(negedge clk);
    fixStb = 1'b0;
    check("R8 second valid", stepValid, 1);
    check("R8 second lat", latStep, 150);
    check("R8 second lon", lonStep, 1500);
    @(negedge clk);
    check("R8 pulse ends", stepValid, 0);
    refLat = 32'sd250; refLon = -32'sd179999500;
  endtask

  initial begin
    refLat = '0; refLon = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFirst();
    testSameSign();
    testMixedFar();
    testCross();
    testThreshold();
    testHold();
    testBackToBack();
    feed("R6 after pair", 32'sd260, 32'sd179999999);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule